// File: doc/BRIEF.md
# Iterative AES-128 Encryption Core with Round-Fault Port

This block encrypts one 128-bit block with a 128-bit key under AES-128. A start strobe loads the plaintext and key. The core whitens the plaintext with the key, then runs one round per clock for ten clocks. It derives each round key from the previous one in the same cycle that the key is used. The result is latched into a ciphertext register, and a single-cycle done pulse marks it as valid.

Two hooks let fault-injection or test logic attach without reaching into the datapath. The first is the round counter, which is exported on a port. The second is a 128-bit mask input. While the fault-enable input is high, the mask is XORed into the state as it enters the current round. An outside trigger can therefore compare the exported round number against a target and corrupt exactly one round. When the enable is low or the mask is zero, the core computes the plain cipher.

Top module: `aes_core`

## Requirements
- R1: After reset, round_o is 0, busy_o is 0, done_o is 0 and cipher_o is all zeros.
- R2: A start_i seen at a clock edge while idle makes round_o equal 1 after that edge. round_o then rises by one at each following edge up to 10 and returns to 0 at the next edge. busy_o is high exactly while round_o is nonzero.
- R3: done_o is high for exactly one cycle. That cycle follows the edge that completes round 10, which is the 11th edge counting the start edge as the first, and cipher_o carries the result in that cycle.
- R4: cipher_o equals the AES-128 encryption of the loaded plaintext under the loaded key. Both 128-bit values are taken in standard byte order, most significant byte first.
- R5: start_i asserted while busy_o is high is ignored: the round sequence and the result of the running operation do not change.
- R6: The mask is XORed into the state before SubBytes of round r when fault_en_i is high in the cycle where round_o equals r. Bits [127-8k -: 8] hold state byte k, which is matrix row k mod 4, column k div 4.
- R7: With fault_en_i low, any mask value has no effect on cipher_o. With fault_en_i high and an all-zero mask, cipher_o is also unaffected.
- R8: A single-bit fault applied in round 9 changes exactly 4 of the 16 ciphertext bytes. A single-bit fault applied in round 8 changes all 16.
- R9: cipher_o holds its value between done pulses, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load plaintext and key, begin encryption (ignored while busy) |
| plain_i | input | 128 | Plaintext block |
| key_i | input | 128 | Cipher key |
| fault_en_i | input | 1 | Apply fault_mask_i to the state entering the current round |
| fault_mask_i | input | 128 | State XOR mask (one-hot or zero) |
| busy_o | output | 1 | Encryption in progress |
| round_o | output | 4 | Current round number, 0 when idle |
| done_o | output | 1 | One-cycle result-valid pulse |
| cipher_o | output | 128 | Registered ciphertext |

## Verification
A fault and a round can share a cycle: the fault is applied in the same cycle that the round it corrupts is computed. The bench raises fault_en_i by itself whenever round_o matches a target round. The faulted ciphertext is then compared against an independent model that XORs the mask before that round's SubBytes. A stray start strobe can also land in the middle of a running operation. The bench checks both that the round counter keeps its step and that the delivered result belongs to the first operation. For the round-8 and round-9 faults, the bench also counts how many ciphertext bytes differ from the clean result.

// File: rtl/aes_pkg.sv
package aes_pkg;
  localparam int unsigned BLK_W  = 128;
  localparam int unsigned NROUND = 10;
  localparam int unsigned RND_W  = $clog2(NROUND + 1);

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = '0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xtime(x);
    end
    return p;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  // inverse as x^254 = x^2 * x^4 * ... * x^128, then affine map
  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] sq, acc, a;
    sq  = x;
    acc = 8'h01;
    for (int i = 0; i < 7; i++) begin
      sq  = gf_mul(sq, sq);
      acc = gf_mul(acc, sq);
    end
    a = acc ^ rotl8(acc, 1) ^ rotl8(acc, 2) ^ rotl8(acc, 3) ^ rotl8(acc, 4) ^ 8'h63;
    return a;
  endfunction

  function automatic logic [7:0] rcon(input logic [RND_W-1:0] rnd);
    logic [7:0] v;
    v = 8'h01;
    for (int i = 1; i < NROUND; i++)
      if (i < int'(rnd)) v = xtime(v);
    return v;
  endfunction
endpackage

// File: rtl/aes_sub_bytes.sv
module aes_sub_bytes #(
  parameter int unsigned NB = 16
) (
  input  logic [8*NB-1:0] din_i,
  output logic [8*NB-1:0] dout_o
);
  for (genvar k = 0; k < NB; k++) begin : g_sb
    assign dout_o[8*k +: 8] = aes_pkg::sbox(din_i[8*k +: 8]);
  end
endmodule

// File: rtl/aes_key_step.sv
module aes_key_step
  import aes_pkg::*;
(
  input  logic [BLK_W-1:0] rk_i,
  input  logic [7:0]       rcon_i,
  output logic [BLK_W-1:0] rk_o
);
  localparam int unsigned WW = 32;
  localparam int unsigned NW = BLK_W / WW;

  logic [WW-1:0] w_in  [NW];
  logic [WW-1:0] w_out [NW];
  logic [WW-1:0] rot_w, sub_w, tmp_w;

  for (genvar i = 0; i < NW; i++) begin : g_split
    assign w_in[i] = rk_i[BLK_W-1-WW*i -: WW];
    assign rk_o[BLK_W-1-WW*i -: WW] = w_out[i];
  end

  assign rot_w = {w_in[NW-1][WW-9:0], w_in[NW-1][WW-1 -: 8]};

  aes_sub_bytes #(.NB(4)) u_sw (.din_i(rot_w), .dout_o(sub_w));

  assign tmp_w = sub_w ^ {rcon_i, 24'h0};

  always_comb begin
    w_out[0] = w_in[0] ^ tmp_w;
    for (int i = 1; i < NW; i++) w_out[i] = w_in[i] ^ w_out[i-1];
  end
endmodule

// File: rtl/aes_round.sv
module aes_round
  import aes_pkg::*;
(
  input  logic [BLK_W-1:0] state_i,
  input  logic [BLK_W-1:0] rkey_i,
  input  logic             last_i,
  output logic [BLK_W-1:0] state_o
);
  localparam int unsigned NB = BLK_W / 8;
  localparam int unsigned NC = 4;

  logic [BLK_W-1:0] sb, sh, mx;

  aes_sub_bytes #(.NB(NB)) u_sb (.din_i(state_i), .dout_o(sb));

  // byte k sits at [BLK_W-1-8k -: 8]; row k%4, column k/4
  for (genvar c = 0; c < NC; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      assign sh[BLK_W-1-8*(4*c+r) -: 8] = sb[BLK_W-1-8*(4*((c+r)%NC)+r) -: 8];
    end
    logic [7:0] a0, a1, a2, a3;
    assign a0 = sh[BLK_W-1-8*(4*c+0) -: 8];
    assign a1 = sh[BLK_W-1-8*(4*c+1) -: 8];
    assign a2 = sh[BLK_W-1-8*(4*c+2) -: 8];
    assign a3 = sh[BLK_W-1-8*(4*c+3) -: 8];
    assign mx[BLK_W-1-8*(4*c+0) -: 8] = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
    assign mx[BLK_W-1-8*(4*c+1) -: 8] = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
    assign mx[BLK_W-1-8*(4*c+2) -: 8] = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
    assign mx[BLK_W-1-8*(4*c+3) -: 8] = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);
  end

  assign state_o = (last_i ? sh : mx) ^ rkey_i;
endmodule

// File: rtl/aes_core.sv
module aes_core
  import aes_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [127:0]     plain_i,
  input  logic [127:0]     key_i,
  input  logic             fault_en_i,
  input  logic [127:0]     fault_mask_i,
  output logic             busy_o,
  output logic [3:0]       round_o,
  output logic             done_o,
  output logic [127:0]     cipher_o
);
  logic [BLK_W-1:0] state_q, rkey_q, cipher_q;
  logic [BLK_W-1:0] round_in, rkey_nx, state_nx;
  logic [RND_W-1:0] round_q;
  logic             done_q, busy, last;

  assign busy     = (round_q != '0);
  assign last     = (round_q == RND_W'(NROUND));
  assign round_in = state_q ^ (fault_en_i ? fault_mask_i : '0);

  aes_key_step u_ks (
    .rk_i   (rkey_q),
    .rcon_i (rcon(round_q)),
    .rk_o   (rkey_nx)
  );

  aes_round u_rnd (
    .state_i (round_in),
    .rkey_i  (rkey_nx),
    .last_i  (last),
    .state_o (state_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= '0;
      rkey_q   <= '0;
      cipher_q <= '0;
      round_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy) begin
        if (start_i) begin
          state_q <= plain_i ^ key_i;
          rkey_q  <= key_i;
          round_q <= RND_W'(1);
        end
      end else begin
        state_q <= state_nx;
        rkey_q  <= rkey_nx;
        if (last) begin
          cipher_q <= state_nx;
          done_q   <= 1'b1;
          round_q  <= '0;
        end else begin
          round_q <= round_q + RND_W'(1);
        end
      end
    end
  end

  assign busy_o   = busy;
  assign round_o  = 4'(round_q);
  assign done_o   = done_q;
  assign cipher_o = cipher_q;

  assert_round_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !last) |=> (round_q == $past(round_q) + RND_W'(1)));
  assert_round_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    round_q <= RND_W'(NROUND));
  assert_last_round_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> (done_o && !busy_o));
  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_ignore_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && start_i && !last) |=> (round_q == $past(round_q) + RND_W'(1)));
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(cipher_o));
  assert_mask_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_en_i |-> $onehot0(fault_mask_i));
endmodule

// File: tb/sim_aes_core.sv
`timescale 1ns/1ps
module sim_aes_core;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] plain = '0, key = '0, mask = '0;
  logic         arm = 1'b0;
  logic [3:0]   tgt = '0;
  logic         fault_en;
  logic         busy, done;
  logic [3:0]   round;
  logic [127:0] cipher;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  assign fault_en = arm && (round == tgt);

  aes_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .plain_i(plain), .key_i(key),
    .fault_en_i(fault_en), .fault_mask_i(mask), .busy_o(busy), .round_o(round),
    .done_o(done), .cipher_o(cipher)
  );

  // ---------------- reference model ----------------
  logic [7:0] tb_sb [256];

  function automatic logic [7:0] tb_gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 0;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] tb_calc_sbox(input logic [7:0] x);
    logic [7:0] inv = 0, o;
    for (int c = 1; c < 256; c++) if (tb_gmul(x, 8'(c)) == 8'h01) inv = 8'(c);
    for (int i = 0; i < 8; i++)
      o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1);
    return o;
  endfunction

  function automatic logic [127:0] tb_encrypt(input logic [127:0] pt, input logic [127:0] k,
                                              input logic [127:0] fm, input int frnd);
    logic [7:0] s [4][4];
    logic [7:0] t [4][4];
    logic [31:0] w [44];
    logic [31:0] tw;
    logic [7:0] rc = 8'h01;
    logic [127:0] o;
    for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      tw = w[i-1];
      if (i % 4 == 0) begin
        tw = {tb_sb[tw[23:16]], tb_sb[tw[15:8]], tb_sb[tw[7:0]], tb_sb[tw[31:24]]} ^ {rc, 24'h0};
        rc = tb_gmul(rc, 8'h02);
      end
      w[i] = w[i-4] ^ tw;
    end
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        s[r][c] = pt[127-8*(4*c+r) -: 8] ^ w[c][31-8*r -: 8];
    for (int rn = 1; rn <= 10; rn++) begin
      if (rn == frnd)
        for (int c = 0; c < 4; c++)
          for (int r = 0; r < 4; r++) s[r][c] ^= fm[127-8*(4*c+r) -: 8];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) t[r][c] = tb_sb[s[r][(c+r)%4]];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          if (rn < 10)
            s[r][c] = tb_gmul(t[r][c], 8'h02) ^ tb_gmul(t[(r+1)%4][c], 8'h03)
                    ^ t[(r+2)%4][c] ^ t[(r+3)%4][c];
          else
            s[r][c] = t[r][c];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) s[r][c] ^= w[4*rn+c][31-8*r -: 8];
    end
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) o[127-8*(4*c+r) -: 8] = s[r][c];
    return o;
  endfunction

  function automatic int diff_bytes(input logic [127:0] a, input logic [127:0] b);
    int n = 0;
    for (int i = 0; i < 16; i++) if (a[8*i +: 8] != b[8*i +: 8]) n++;
    return n;
  endfunction

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // pt, key, mask, fault round (0 = none); restart injects a stray start mid-run
  task automatic run_op(input logic [127:0] pt, input logic [127:0] k, input logic [127:0] m,
                        input int frnd, input bit restart, output logic [127:0] ct);
    bit seq_ok = 1;
    @(negedge clk);
    plain = pt; key = k; mask = m; tgt = 4'(frnd); arm = (frnd != 0); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int r = 1; r <= 10; r++) begin
      if (round != 4'(r) || !busy || done) seq_ok = 0;
      if (restart && r == 3) begin
        start = 1'b1; plain = ~pt; key = ~k;
      end else if (restart && r == 4) begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    chk(seq_ok, "R2 round sequence", 128'(round), 128'(0));
    chk(done && round == 0 && !busy, "R3 done after round 10", {busy, done, round}, 128'h10);
    ct = cipher;
    arm = 1'b0; mask = '0;
    @(negedge clk);
    chk(!done, "R3 done single cycle", 128'(done), 128'(0));
  endtask

  localparam int NVEC = 2;
  localparam logic [383:0] VEC [NVEC] = '{
    {128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c,
     128'h3925841d02dc09fbdc118597196a0b32},
    {128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f,
     128'h69c4e0d86a7b0430d8cdb78070b4c55a}
  };

  initial begin
    logic [127:0] ct, ct0, pt, k, ex;
    for (int i = 0; i < 256; i++) tb_sb[i] = tb_calc_sbox(8'(i));
    repeat (3) @(negedge clk);
    // R1
    chk(round == 0 && !busy && !done && cipher == '0, "R1 reset state", cipher, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(round == 0 && !busy && !done, "R1 idle after reset", 128'(round), '0);

    // R4 known-answer table
    for (int v = 0; v < NVEC; v++) begin
      run_op(VEC[v][383:256], VEC[v][255:128], '0, 0, 0, ct);
      chk(ct == VEC[v][127:0], "R4 known vector", ct, VEC[v][127:0]);
      chk(ct == tb_encrypt(VEC[v][383:256], VEC[v][255:128], '0, 0), "R4 model agrees", ct, VEC[v][127:0]);
    end

    // R4 random vectors
    for (int v = 0; v < 6; v++) begin
      pt = {$urandom, $urandom, $urandom, $urandom};
      k  = {$urandom, $urandom, $urandom, $urandom};
      run_op(pt, k, '0, 0, 0, ct);
      ex = tb_encrypt(pt, k, '0, 0);
      chk(ct == ex, "R4 random vector", ct, ex);
    end

    // R9 hold
    ct0 = cipher;
    plain = '1; key = '1; mask = 128'h1; arm = 1'b1; tgt = 4'd0;
    repeat (4) @(negedge clk);
    chk(cipher == ct0 && !done, "R9 cipher holds", cipher, ct0);
    arm = 1'b0; mask = '0;

    // R5 stray start during run
    pt = VEC[0][383:256]; k = VEC[0][255:128];
    run_op(pt, k, '0, 0, 1, ct);
    chk(ct == VEC[0][127:0], "R5 start ignored while busy", ct, VEC[0][127:0]);

    // R6 faults on several rounds and bit positions
    for (int f = 1; f <= 10; f += 3) begin
      logic [127:0] m = 128'h1 << (13 * f);
      run_op(pt, k, m, f, 0, ct);
      ex = tb_encrypt(pt, k, m, f);
      chk(ct == ex, "R6 faulted round result", ct, ex);
    end

    // R7 mask with enable low, zero mask with enable high
    @(negedge clk);
    mask = 128'h80; start = 1'b1; plain = pt; key = k; arm = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    chk(done && cipher == VEC[0][127:0], "R7 mask ignored without enable", cipher, VEC[0][127:0]);
    mask = '0;
    run_op(pt, k, '0, 5, 0, ct);
    chk(ct == VEC[0][127:0], "R7 zero mask no effect", ct, VEC[0][127:0]);

    // R8 fault spread
    run_op(pt, k, 128'h1 << 100, 9, 0, ct);
    chk(diff_bytes(ct, VEC[0][127:0]) == 4, "R8 round 9 fault spreads to 4 bytes",
        128'(diff_bytes(ct, VEC[0][127:0])), 128'd4);
    run_op(pt, k, 128'h1 << 37, 8, 0, ct);
    chk(diff_bytes(ct, VEC[0][127:0]) == 16, "R8 round 8 fault spreads to 16 bytes",
        128'(diff_bytes(ct, VEC[0][127:0])), 128'd16);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule